// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is a byte-wide, register-mapped master for an open-drain single-wire serial bus. A host reaches five registers: command, data, status, interrupt mask and clock divisor. From a bus reset command it makes the reset low pulse and looks for a slave's presence answer. A byte written to the data register goes out as eight time slots, least significant bit first. A byte read works by sending all-ones while the block samples the line in each slot.

The pad is modelled as a drive-low output and a sampled line input. A divider outside the block supplies a one-tick-per-microsecond strobe `tick`, and every timing count advances only on that strobe. The divisor register exists only so the host can program that external divider. Status events raise one interrupt line whose active level the host chooses. Reading the status register clears the interrupt and the one-shot events. Reading the data register clears the receive-full flag.

Top module: `owm_ctrl`

## Requirements
- R1: The register index is `addr >> ADDR_SHIFT`. The indices are command 0, data 1, status 2, mask 3 and divisor 4. The divisor register reads back the value written and drives `div_cfg`.
- R2: After reset the status register reads 0x0C, `irq_o` is 1 (inactive) and `bus_low` is 0. Status bits are: 0 reset done, 1 no-presence, 2 transmit buffer empty, 3 transmit shifter empty, 4 receive full, 5 receive overrun.
- R3: Writing command bit 0 while idle drives `bus_low` for 480 ticks. The line is sampled at tick 550 and the sequence ends at tick 960. At that point status bit 0 sets, and status bit 1 takes the sampled line level (1 = no slave answered). No count advances on a cycle with `tick` low.
- R4: Each data byte is sent least significant bit first in slots of 62 ticks. A 0 bit holds `bus_low` for 60 ticks and a 1 bit for 6 ticks.
- R5: A data write clears status bit 2. Bit 2 sets again when the byte moves into the shifter. Bit 3 is 0 from that move until the last slot ends.
- R6: When the byte sent was 0xFF, the line levels sampled at tick 15 of each slot form the received byte, least significant bit first. That byte goes to the data register and status bit 4 sets. Any other byte leaves the receive buffer and bit 4 unchanged.
- R7: Reading the data register clears status bit 4.
- R8: If a received byte completes while bit 4 is still set, the buffer keeps its old value and status bit 5 sets.
- R9: The interrupt goes pending when a status bit rises while its mask bit is set. Mask bits 0, 2, 3, 4 and 5 match the status bits of the same number. A status read clears the pending state, bit 0 and bit 5. `irq_o` equals the pending state when mask bit 1 is 1, and its inverse otherwise.
- R10: Command bit 2 forces `bus_low` only when mask bit 6 is set. Command read bit 3 returns the live `bus_in` level.
- R11: Command bit 5 abandons any bus activity and returns every register except the divisor to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-microsecond timing strobe from the external divider |
| addr | input | ADDR_W | Host byte address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; read side effects apply at the clock edge |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from `addr` |
| bus_in | input | 1 | Sampled line level |
| bus_low | output | 1 | 1 pulls the open-drain line low |
| irq_o | output | 1 | Interrupt, polarity set by mask bit 1 |
| div_cfg | output | 8 | Divisor value for the external tick divider |

## Verification
The assertions assume the host never issues a read and a write in the same cycle. They also assume a soft reset is the only way an active sequence ends early. Under those assumptions a handed-off byte always starts slotting, and a clearing read always lands. The bench applies one strobe at a time. It waits out each sequence before touching the data or command register, except in the deliberate back-to-back and abort cases. The slave model answers only on slot and reset edges it sees on `bus_low`.

// File: rtl/owm_pkg.sv
// Shared register indices, bit positions and sequencer state for the
// single-wire bus master. Assumes byte-wide host registers.
package owm_pkg;
    localparam int BYTE_W   = 8;
    // register indices (after address shift)
    localparam int REG_CMD  = 0;
    localparam int REG_DATA = 1;
    localparam int REG_STAT = 2;
    localparam int REG_MASK = 3;
    localparam int REG_DIV  = 4;
    // status bits
    localparam int ST_DONE  = 0;
    localparam int ST_NOPRS = 1;
    localparam int ST_TXE   = 2;
    localparam int ST_SHE   = 3;
    localparam int ST_RXF   = 4;
    localparam int ST_OVR   = 5;
    // command bits
    localparam int CM_BUSRST = 0;
    localparam int CM_FORCE  = 2;
    localparam int CM_LEVEL  = 3;
    localparam int CM_SOFT   = 5;
    // mask register special bits
    localparam int MK_POL    = 1;
    localparam int MK_DRIVE  = 6;

    typedef enum logic [1:0] {SQ_IDLE, SQ_RST, SQ_BITS} seq_state_t;
endpackage

// File: rtl/owm_seq.sv
// Line timing engine: produces the bus reset/presence sequence and the
// byte-wide time slots, counting only on cycles where tick is high.
// Assumes go_rst and go_byte arrive only while idle; abort wins over all.
module owm_seq
    import owm_pkg::*;
#(
    parameter int RST_LOW   = 480,
    parameter int PRES_AT   = 550,
    parameter int RST_END   = 960,
    parameter int SLOT_LEN  = 62,
    parameter int ZERO_LOW  = 60,
    parameter int ONE_LOW   = 6,
    parameter int SAMPLE_AT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              tick,
    input  logic              go_rst,
    input  logic              go_byte,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              line_in,
    output logic              drive_low,
    output logic              busy,
    output logic              in_bits,
    output logic              pd_done,
    output logic              pd_none,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CW = $clog2(RST_END);
    localparam int BW = $clog2(BYTE_W);

    seq_state_t        state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [BYTE_W-1:0] shtx;
    logic [BYTE_W-1:0] shrx;

    // Sequencer state, tick counter, shift registers and done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shtx      <= '0;
            shrx      <= '0;
            pd_done   <= 1'b0;
            pd_none   <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            pd_done   <= 1'b0;
            byte_done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    cnt  <= '0;
                    bitn <= '0;
                    if (go_rst) begin
                        state <= SQ_RST;
                    end else if (go_byte) begin
                        state <= SQ_BITS;
                        shtx  <= tx_byte;
                    end
                end
                SQ_RST: if (tick) begin
                    if (cnt == CW'(PRES_AT)) pd_none <= line_in;
                    if (cnt == CW'(RST_END - 1)) begin
                        state   <= SQ_IDLE;
                        pd_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_BITS: if (tick) begin
                    if (cnt == CW'(SAMPLE_AT)) shrx <= {line_in, shrx[BYTE_W-1:1]};
                    if (cnt == CW'(SLOT_LEN - 1)) begin
                        cnt  <= '0;
                        shtx <= shtx >> 1;
                        if (bitn == BW'(BYTE_W - 1)) begin
                            state     <= SQ_IDLE;
                            byte_done <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Line drive: reset low phase, or the low part of the current slot.
    always_comb begin
        case (state)
            SQ_RST:  drive_low = (cnt < CW'(RST_LOW));
            SQ_BITS: drive_low = shtx[0] ? (cnt < CW'(ONE_LOW)) : (cnt < CW'(ZERO_LOW));
            default: drive_low = 1'b0;
        endcase
    end

    assign busy    = (state != SQ_IDLE);
    assign in_bits = (state == SQ_BITS);
    assign rx_byte = shrx;

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && !tick && !abort) |=> $stable(cnt)); // R3
    AST_BYTE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BITS && tick && !abort && cnt == CW'(SLOT_LEN - 1) && bitn == BW'(BYTE_W - 1))
        |=> (state == SQ_IDLE && byte_done)); // R4
endmodule

// File: rtl/owm_regs.sv
// Host register file: command decode, transmit buffer hand-off, status
// flags with read side effects, and the polarity-selectable interrupt.
// Assumes at most one of wr_en/rd_en per cycle; soft reset keeps divisor.
module owm_regs
    import owm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              line_in,
    input  logic              seq_busy,
    input  logic              seq_bits,
    input  logic              pd_done,
    input  logic              pd_none,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              go_rst,
    output logic              go_byte,
    output logic              abort,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              force_low,
    output logic [BYTE_W-1:0] div_cfg,
    output logic              irq_o
);
    logic              wr_cmd, wr_data, wr_mask, wr_div, rd_data, rd_stat;
    logic              txfull, last_ff, pd, pdr, rbf, rsrf, force_q, pend, evt, rx_load;
    logic [BYTE_W-1:0] txbuf, rxbuf, divq, stat, stat_q, ev_mask;
    logic [6:0]        mask;

    assign wr_cmd  = wr_en && (sel == 3'(REG_CMD));
    assign wr_data = wr_en && (sel == 3'(REG_DATA));
    assign wr_mask = wr_en && (sel == 3'(REG_MASK));
    assign wr_div  = wr_en && (sel == 3'(REG_DIV));
    assign rd_data = rd_en && (sel == 3'(REG_DATA));
    assign rd_stat = rd_en && (sel == 3'(REG_STAT));

    assign abort   = wr_cmd && wdata[CM_SOFT];
    assign go_rst  = wr_cmd && wdata[CM_BUSRST] && !abort && !seq_busy;
    assign go_byte = txfull && !seq_busy && !go_rst && !abort;
    assign tx_byte = txbuf;
    assign rx_load = byte_done && last_ff;

    assign stat    = {2'b00, rsrf, rbf, !txfull && !seq_bits, !txfull, pdr, pd};
    assign ev_mask = {2'b00, mask[5:2], 1'b0, mask[0]};
    assign evt     = |(stat & ~stat_q & ev_mask);

    // Buffers, flags, mask, force and interrupt pending state.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            txfull  <= 1'b0;
            txbuf   <= '0;
            last_ff <= 1'b0;
            pd      <= 1'b0;
            pdr     <= 1'b0;
            rbf     <= 1'b0;
            rsrf    <= 1'b0;
            rxbuf   <= '0;
            mask    <= '0;
            force_q <= 1'b0;
            pend    <= 1'b0;
            stat_q  <= 8'h0C;
        end else begin
            if (go_byte) begin
                txfull  <= 1'b0;
                last_ff <= (txbuf == 8'hFF);
            end
            if (wr_data) begin
                txbuf  <= wdata;
                txfull <= 1'b1;
            end
            if (rd_stat) begin
                pd   <= 1'b0;
                rsrf <= 1'b0;
            end
            if (pd_done) begin
                pd  <= 1'b1;
                pdr <= pd_none;
            end
            if (rd_data) rbf <= 1'b0;
            if (rx_load) begin
                if (rbf) begin
                    rsrf <= 1'b1;
                end else begin
                    rxbuf <= rx_byte;
                    rbf   <= 1'b1;
                end
            end
            if (wr_mask) mask <= wdata[6:0];
            if (wr_cmd) force_q <= wdata[CM_FORCE] && mask[MK_DRIVE];
            stat_q <= stat;
            if (rd_stat) pend <= 1'b0;
            if (evt) pend <= 1'b1;
        end
    end

    // Divisor survives the soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) divq <= '0;
        else if (wr_div) divq <= wdata;
    end

    // Host read mux.
    always_comb begin
        rdata = '0;
        case (sel)
            3'(REG_CMD): begin
                rdata[CM_LEVEL] = line_in;
                rdata[CM_FORCE] = force_q;
            end
            3'(REG_DATA): rdata = rxbuf;
            3'(REG_STAT): rdata = stat;
            3'(REG_MASK): rdata = {1'b0, mask};
            3'(REG_DIV):  rdata = divq;
            default:      rdata = '0;
        endcase
    end

    assign force_low = force_q;
    assign div_cfg   = divq;
    assign irq_o     = mask[MK_POL] ? pend : !pend;

    AST_HANDOFF_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        go_byte |=> seq_bits); // R5
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !evt && !wr_en) |=> (irq_o != mask[MK_POL])); // R9
    AST_RXF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_load) |=> !rbf); // R7
    AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && rbf && !rd_data && !abort) |=> (rsrf && $stable(rxbuf))); // R8
endmodule

// File: rtl/owm_ctrl.sv
// Top of the single-wire bus master: address decode with a configurable
// shift, register file and line timing engine. Assumes tick is a
// one-cycle strobe at the slot time base and bus_in is already synchronous.
module owm_ctrl
    import owm_pkg::*;
#(
    parameter int ADDR_SHIFT = 0,
    parameter int ADDR_W     = 3 + ADDR_SHIFT,
    parameter int RST_LOW    = 480,
    parameter int PRES_AT    = 550,
    parameter int RST_END    = 960,
    parameter int SLOT_LEN   = 62,
    parameter int ZERO_LOW   = 60,
    parameter int ONE_LOW    = 6,
    parameter int SAMPLE_AT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              bus_in,
    output logic              bus_low,
    output logic              irq_o,
    output logic [7:0]        div_cfg
);
    logic [ADDR_W-1:0] idx_full;
    logic [2:0]        sel;
    logic              go_rst, go_byte, abort, force_low, seq_low;
    logic              seq_busy, seq_bits, pd_done, pd_none, byte_done;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    assign idx_full = addr >> ADDR_SHIFT;
    assign sel      = idx_full[2:0];

    owm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .line_in(bus_in),
        .seq_busy(seq_busy), .seq_bits(seq_bits), .pd_done(pd_done),
        .pd_none(pd_none), .byte_done(byte_done), .rx_byte(rx_byte),
        .go_rst(go_rst), .go_byte(go_byte), .abort(abort), .tx_byte(tx_byte),
        .force_low(force_low), .div_cfg(div_cfg), .irq_o(irq_o)
    );

    owm_seq #(
        .RST_LOW(RST_LOW), .PRES_AT(PRES_AT), .RST_END(RST_END),
        .SLOT_LEN(SLOT_LEN), .ZERO_LOW(ZERO_LOW), .ONE_LOW(ONE_LOW),
        .SAMPLE_AT(SAMPLE_AT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .abort(abort), .tick(tick),
        .go_rst(go_rst), .go_byte(go_byte), .tx_byte(tx_byte), .line_in(bus_in),
        .drive_low(seq_low), .busy(seq_busy), .in_bits(seq_bits),
        .pd_done(pd_done), .pd_none(pd_none), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    assign bus_low = seq_low | force_low;
endmodule

// File: tb/sim_owm_ctrl.sv
module sim_owm_ctrl;
    localparam int SH = 2;
    logic       clk = 1'b0;
    logic       rst_n, tick, wr_en, rd_en;
    logic [4:0] addr;
    logic [7:0] wdata, rdata, div_cfg;
    logic       bus_in, bus_low, irq_o;

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    // slave model state
    bit       prev_low = 0, slave_present = 1, rd_mode = 0;
    int       low_len = 0, pull_cnt = 0, pres_dly = 0, rst_len = 0, rd_idx = 0, wr_bits = 0;
    logic [7:0] rd_val = 8'h00, wr_shift = 8'h00;

    always #10 clk = ~clk;

    owm_ctrl #(.ADDR_SHIFT(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .bus_in(bus_in),
        .bus_low(bus_low), .irq_o(irq_o), .div_cfg(div_cfg)
    );

    assign bus_in = !(bus_low || (pull_cnt != 0));

    // bus slave: presence answer, bit decode, read-slot answers
    always @(posedge clk) begin
        prev_low <= bus_low;
        if (pull_cnt > 0) pull_cnt <= pull_cnt - 1;
        if (pres_dly > 0) begin
            pres_dly <= pres_dly - 1;
            if (pres_dly == 1) pull_cnt <= 120;
        end
        if (bus_low && !prev_low) begin
            low_len <= 1;
            if (rd_mode) begin
                if (!rd_val[rd_idx[2:0]]) pull_cnt <= 30;
                rd_idx <= rd_idx + 1;
            end
        end else if (bus_low) begin
            low_len <= low_len + 1;
        end
        if (!bus_low && prev_low) begin
            if (low_len > 200) begin
                rst_len <= low_len;
                if (slave_present) pres_dly <= 15;
            end else begin
                wr_shift <= {(low_len < 30), wr_shift[7:1]};
                wr_bits  <= wr_bits + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input int idx, input logic [7:0] v);
        @(negedge clk);
        addr = 5'(idx << SH); wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output logic [7:0] v);
        @(negedge clk);
        addr = 5'(idx << SH); rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected status bits field extraction
    function automatic logic [1:0] fld2(input logic [7:0] s, input int pos);
        return 2'((s >> pos) & 8'h3);
    endfunction

    task automatic slave_read(input logic [7:0] val);
        rd_val = val; rd_idx = 0; rd_mode = 1;
        reg_wr(1, 8'hFF);
        wait_cyc(540);
        rd_mode = 0;
    endtask

    initial begin
        logic [7:0] v, b, v1, v2;
        void'($urandom(32'd4177));
        rst_n = 0; tick = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(1);

        reg_rd(2, v);
        check("R2 status after reset", v, 8'h0C);
        check("R2 irq inactive", irq_o, 1);
        check("R2 line released", bus_low, 0);

        reg_wr(4, 8'h8C);
        reg_rd(4, v);
        check("R1 divisor readback", v, 8'h8C);
        check("R1 divisor output", div_cfg, 8'h8C);

        // bus reset with slave present, PD interrupt active low
        reg_wr(3, 8'h01);
        reg_wr(0, 8'h01);
        wait_cyc(1000);
        check("R3 reset low length", rst_len, 480);
        check("R9 irq on reset done", irq_o, 0);
        reg_rd(2, v);
        check("R3 presence seen", fld2(v, 0), 2'b01);
        check("R9 irq cleared by status read", irq_o, 1);
        reg_rd(2, v);
        check("R9 done bit cleared by read", v[0], 0);

        // bus reset with no slave
        slave_present = 0;
        reg_wr(0, 8'h01);
        wait_cyc(1000);
        reg_rd(2, v);
        check("R3 no presence", fld2(v, 0), 2'b11);
        slave_present = 1;

        // back-to-back writes: flags and decode
        reg_wr(3, 8'h0A);
        check("R9 active-high idle", irq_o, 0);
        wr_bits = 0;
        reg_wr(1, 8'hA5);
        wait_cyc(5);
        reg_rd(2, v);
        check("R5 moved to shifter", fld2(v, 2), 2'b01);
        reg_wr(1, 8'h3C);
        reg_rd(2, v);
        check("R5 buffer full while shifting", fld2(v, 2), 2'b00);
        wait_cyc(1100);
        check("R4 second byte on line", wr_shift, 8'h3C);
        check("R4 slot count", wr_bits, 16);
        check("R9 irq on shifter empty", irq_o, 1);
        reg_rd(2, v);
        check("R5 both empty", fld2(v, 2), 2'b11);
        check("R9 irq dropped", irq_o, 0);

        // random bytes
        for (int i = 0; i < 6; i++) begin
            b = 8'($urandom);
            if (b == 8'hFF) b = 8'h00;
            wr_bits = 0;
            reg_wr(1, b);
            wait_cyc(540);
            check("R4 random byte on line", wr_shift, b);
            check("R4 random slot count", wr_bits, 8);
        end

        // reads with RX-full interrupt active low
        reg_wr(3, 8'h10);
        for (int i = 0; i < 4; i++) begin
            b = (i == 0) ? 8'h00 : 8'($urandom);
            reg_rd(1, v);
            slave_read(b);
            check("R9 irq on rx full", irq_o, 0);
            reg_rd(2, v);
            check("R6 rx full set", v[4], 1);
            reg_rd(1, v);
            check("R6 received byte", v, b);
            reg_rd(2, v);
            check("R7 rx full cleared", v[4], 0);
        end

        // non-0xFF byte leaves receive side alone
        reg_rd(1, v1);
        rd_val = 8'h00; rd_idx = 0; rd_mode = 1;
        reg_wr(1, 8'h12);
        wait_cyc(540);
        rd_mode = 0;
        reg_rd(2, v);
        check("R6 no rx on plain write", v[4], 0);
        reg_rd(1, v);
        check("R6 buffer unchanged", v, v1);

        // overrun
        v1 = 8'h5A; v2 = 8'hC3;
        slave_read(v1);
        slave_read(v2);
        reg_rd(2, v);
        check("R8 overrun flags", fld2(v, 4), 2'b11);
        reg_rd(1, v);
        check("R8 buffer kept", v, v1);
        reg_rd(2, v);
        check("R8 overrun cleared by read", v[5], 0);

        // direct drive
        reg_wr(3, 8'h40);
        reg_wr(0, 8'h04);
        check("R10 forced low", bus_low, 1);
        reg_rd(0, v);
        check("R10 level reads low", v[3], 0);
        reg_wr(0, 8'h00);
        check("R10 released", bus_low, 0);
        reg_rd(0, v);
        check("R10 level reads high", v[3], 1);
        reg_wr(3, 8'h00);
        reg_wr(0, 8'h04);
        check("R10 force ignored without enable", bus_low, 0);

        // soft reset mid-byte
        reg_wr(3, 8'h0A);
        reg_wr(1, 8'h00);
        wait_cyc(100);
        check("R11 byte in progress", bus_low, 1);
        reg_wr(0, 8'h20);
        check("R11 line released", bus_low, 0);
        reg_rd(2, v);
        check("R11 status reset", v, 8'h0C);
        reg_rd(3, v);
        check("R11 mask reset", v, 8'h00);
        reg_rd(4, v);
        check("R11 divisor kept", v, 8'h8C);
        wait_cyc(600);
        check("R11 stays released", bus_low, 0);

        // tick gating
        tick = 0;
        reg_wr(0, 8'h01);
        wait_cyc(600);
        check("R3 no advance without tick", bus_low, 1);
        tick = 1;
        wait_cyc(1000);
        reg_rd(2, v);
        check("R3 completes after ticks resume", v[0], 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule